// File: doc/BRIEF.md
# Register Scan-Out Serializer

This block gives non-destructive serial readback of a timing generator's configuration registers and its running counters over one output pin. Selection works through the address space, with no read strobe. When an address write lands in the scan window, the block captures the selected 12-bit word. It also drops the run enable that clocks the timing engine, so every counter holds its value. From then on, each clock shifts the next bit of the captured word onto the pin, least significant bit first.

The pin is shared with the field-parity flag. Whenever no scan is active, the pin carries that flag. Once all twelve bits have been presented, further clocks keep showing the most significant bit. Reading the same word again means writing its scan address again. While the external load strobe is still asserted, shifting waits. Writing any address outside the scan window ends the scan and raises the run enable again. The engine then continues from the exact state at which it was frozen.

Top module: `reg_scan_serializer`

## Requirements
- R1: After reset, run_en is 1 and scan_pin equals field_odd.
- R2: Writing scan address 32+k, for k from 0 to 18, selects register word k (bits k*12 to k*12+11 of reg_flat). On the next cycle scan_pin shows that word's bit 0.
- R3: Writing scan address 51, 52 or 53 selects counter word 0, 1 or 2 of cnt_flat, in the same way as R2.
- R4: run_en is 0 from the cycle after a scan address is accepted until the cycle after a non-scan address is accepted.
- R5: On each clock edge with a scan active, load_hold at 0 and no address write, scan_pin advances to the next higher bit of the captured word.
- R6: After 11 advances, scan_pin shows bit 11. It keeps showing bit 11 on every further advance.
- R7: While load_hold is 1, scan_pin does not advance.
- R8: Writing the same scan address again restarts the scan at bit 0 of a fresh capture.
- R9: Writing any address outside 32 to 53 ends the scan. On the next cycle run_en is 1 and scan_pin follows field_odd.
- R10: The word is captured when its scan address is accepted. Later changes on reg_flat or cnt_flat do not change the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_we | input | 1 | Address write strobe, one cycle per write |
| addr_val | input | 6 | Address being written |
| load_hold | input | 1 | 1 while the external load strobe is still asserted |
| field_odd | input | 1 | Field parity flag, shown on the pin when no scan is active |
| reg_flat | input | 228 | Nineteen 12-bit register words, word k at bits k*12 and up |
| cnt_flat | input | 36 | Three 12-bit counter words |
| scan_pin | output | 1 | Shared serial data / field parity output |
| run_en | output | 1 | Timing engine enable, 0 while frozen for a scan |

## Verification
Two situations are the hardest to reach from the ports: holding the most significant bit after the twelfth bit, and pausing under load_hold partway through a word. Both need long unbroken runs of cycles with no address write. The stimulus scans one register word clean through and then keeps clocking for three more cycles. In a second scan it raises load_hold after the first bit and changes every reg_flat word during the pause. This shows that the shifted bits still come from the captured word.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IDX_W = 6;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_REG  = 2'd1,
        SRC_CNT  = 2'd2
    } src_kind_e;

    typedef struct packed {
        src_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } scan_sel_t;

    function automatic scan_sel_t decode_scan(input logic [IDX_W-1:0] a,
                                              input int base,
                                              input int nreg,
                                              input int ncnt);
        scan_sel_t s;
        int off;
        off    = int'(a) - base;
        s.kind = SRC_NONE;
        s.idx  = '0;
        if (off >= 0 && off < nreg) begin
            s.kind = SRC_REG;
            s.idx  = IDX_W'(off);
        end else if (off >= nreg && off < nreg + ncnt) begin
            s.kind = SRC_CNT;
            s.idx  = IDX_W'(off - nreg);
        end
        return s;
    endfunction

endpackage

// File: rtl/scan_decode.sv
module scan_decode
    import scan_pkg::*;
#(
    parameter int BASE = 32,
    parameter int NREG = 19,
    parameter int NCNT = 3
) (
    input  logic [IDX_W-1:0] addr,
    output scan_sel_t        sel
);
    always_comb begin
        sel = decode_scan(addr, BASE, NREG, NCNT);
    end
endmodule

// File: rtl/scan_mux.sv
module scan_mux
    import scan_pkg::*;
#(
    parameter int W    = 12,
    parameter int NREG = 19,
    parameter int NCNT = 3
) (
    input  scan_sel_t           sel,
    input  logic [NREG*W-1:0]   reg_flat,
    input  logic [NCNT*W-1:0]   cnt_flat,
    output logic [W-1:0]        word
);
    logic [W-1:0] regs [NREG];
    logic [W-1:0] cnts [NCNT];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign regs[g] = reg_flat[g*W +: W];
    end
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        assign cnts[g] = cnt_flat[g*W +: W];
    end

    always_comb begin
        word = '0;
        if (sel.kind == SRC_REG) begin
            for (int i = 0; i < NREG; i++)
                if (sel.idx == IDX_W'(i)) word = regs[i];
        end else if (sel.kind == SRC_CNT) begin
            for (int i = 0; i < NCNT; i++)
                if (sel.idx == IDX_W'(i)) word = cnts[i];
        end
    end
endmodule

// File: rtl/scan_shifter.sv
module scan_shifter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         resume,
    input  logic         advance,
    input  logic [W-1:0] cap_word,
    input  logic         field_odd,
    output logic         pin,
    output logic         run_en
);
    logic [W-1:0] sh_q;
    logic         active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            active_q <= 1'b0;
        end else if (capture) begin
            sh_q     <= cap_word;
            active_q <= 1'b1;
        end else if (resume) begin
            active_q <= 1'b0;
        end else if (active_q && advance) begin
            // top bit is replicated so it persists once the word is spent
            sh_q <= {sh_q[W-1], sh_q[W-1:1]};
        end
    end

    assign pin    = active_q ? sh_q[0] : field_odd;
    assign run_en = ~active_q;
endmodule

// File: rtl/reg_scan_serializer.sv
module reg_scan_serializer
    import scan_pkg::*;
#(
    parameter int W    = 12,
    parameter int NREG = 19,
    parameter int NCNT = 3,
    parameter int BASE = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                addr_we,
    input  logic [IDX_W-1:0]    addr_val,
    input  logic                load_hold,
    input  logic                field_odd,
    input  logic [NREG*W-1:0]   reg_flat,
    input  logic [NCNT*W-1:0]   cnt_flat,
    output logic                scan_pin,
    output logic                run_en
);
    scan_sel_t    sel;
    logic [W-1:0] word;
    logic         capture, resume, advance;

    scan_decode #(.BASE(BASE), .NREG(NREG), .NCNT(NCNT)) u_dec (
        .addr (addr_val),
        .sel  (sel)
    );

    scan_mux #(.W(W), .NREG(NREG), .NCNT(NCNT)) u_mux (
        .sel      (sel),
        .reg_flat (reg_flat),
        .cnt_flat (cnt_flat),
        .word     (word)
    );

    assign capture = addr_we && (sel.kind != SRC_NONE);
    assign resume  = addr_we && (sel.kind == SRC_NONE);
    assign advance = ~load_hold;

    scan_shifter #(.W(W)) u_shf (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .resume    (resume),
        .advance   (advance),
        .cap_word  (word),
        .field_odd (field_odd),
        .pin       (scan_pin),
        .run_en    (run_en)
    );
endmodule

// File: rtl/reg_scan_serializer_chk.sv
module reg_scan_serializer_chk
    import scan_pkg::*;
#(
    parameter int W    = 12,
    parameter int NREG = 19,
    parameter int NCNT = 3,
    parameter int BASE = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             addr_we,
    input logic [IDX_W-1:0] addr_val,
    input logic             load_hold,
    input logic             field_odd,
    input logic             scan_pin,
    input logic             run_en
);
    localparam int CW = $clog2(W + 1);

    scan_sel_t s;
    logic      is_scan;
    logic [CW-1:0] shifts_q;

    assign s       = decode_scan(addr_val, BASE, NREG, NCNT);
    assign is_scan = addr_we && (s.kind != SRC_NONE);

    always_ff @(posedge clk) begin
        if (rst || is_scan) shifts_q <= '0;
        else if (!run_en && !load_hold && !addr_we && shifts_q < CW'(W))
            shifts_q <= shifts_q + 1'b1;
    end

    assert_reset_runs_R1: assert property (@(posedge clk) rst |=> run_en);

    assert_freeze_on_scan_R4: assert property (@(posedge clk) disable iff (rst)
        is_scan |=> !run_en);

    assert_hold_pauses_R7: assert property (@(posedge clk) disable iff (rst)
        (!run_en && load_hold && !addr_we) |=> $stable(scan_pin));

    assert_msb_repeats_R6: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !load_hold && !addr_we && shifts_q >= CW'(W-1)) |=> $stable(scan_pin));

    assert_resume_R9: assert property (@(posedge clk) disable iff (rst)
        (addr_we && !is_scan) |=> (run_en && scan_pin == field_odd));
endmodule

bind reg_scan_serializer reg_scan_serializer_chk #(
    .W(W), .NREG(NREG), .NCNT(NCNT), .BASE(BASE)
) chk_i (
    .clk(clk), .rst(rst), .addr_we(addr_we), .addr_val(addr_val),
    .load_hold(load_hold), .field_odd(field_odd),
    .scan_pin(scan_pin), .run_en(run_en)
);

// File: tb/reg_scan_serializer_tb_top.sv
module reg_scan_serializer_tb_top;
    localparam int W = 12, NREG = 19, NCNT = 3;

    logic clk = 0, rst = 1, addr_we = 0, load_hold = 0, field_odd = 1;
    logic [5:0] addr_val = '0;
    logic [NREG*W-1:0] reg_flat;
    logic [NCNT*W-1:0] cnt_flat;
    logic scan_pin, run_en;

    always #10 clk = ~clk;

    reg_scan_serializer dut_i (
        .clk(clk), .rst(rst), .addr_we(addr_we), .addr_val(addr_val),
        .load_hold(load_hold), .field_odd(field_odd),
        .reg_flat(reg_flat), .cnt_flat(cnt_flat),
        .scan_pin(scan_pin), .run_en(run_en)
    );

    typedef struct { logic pin; logic run; string req; } exp_t;
    exp_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    function automatic logic [W-1:0] regv(int k, bit inv);
        logic [W-1:0] v;
        v = W'(k * 293 + 12'h1A5) ^ W'(k << 7);
        return inv ? ~v : v;
    endfunction
    function automatic logic [W-1:0] cntv(int j);
        return W'(j * 1111 + 77);
    endfunction

    task automatic set_regs(bit inv);
        for (int k = 0; k < NREG; k++) reg_flat[k*W +: W] = regv(k, inv);
        for (int j = 0; j < NCNT; j++) cnt_flat[j*W +: W] = cntv(j);
    endtask

    // one cycle of stimulus, then the expected pin/run after the edge
    task automatic cyc(bit we, int a, bit hold, bit fo, logic ep, logic er, string req);
        @(negedge clk); #1;
        addr_we = we; addr_val = 6'(a); load_hold = hold; field_odd = fo;
        @(posedge clk); #1;
        q.push_back('{pin: ep, run: er, req: req});
    endtask

    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (scan_pin !== e.pin || run_en !== e.run) begin
                errors++;
                $display("FAIL %s: pin=%b run=%b expected pin=%b run=%b",
                         e.req, scan_pin, run_en, e.pin, e.run);
            end
        end
    end

    initial begin
        logic [W-1:0] v;
        set_regs(0);
        // R1: reset state, pin follows field_odd both ways
        cyc(0, 0, 0, 1, 1, 1, "R1");
        cyc(0, 0, 0, 0, 0, 1, "R1");
        rst = 0;
        cyc(0, 0, 0, 1, 1, 1, "R1");

        // R2/R4/R5/R6: scan register 0 fully, then 3 extra clocks
        v = regv(0, 0);
        cyc(1, 32, 0, 1, v[0], 0, "R2_R4");
        for (int b = 1; b < W; b++) cyc(0, 0, 0, 1, v[b], 0, "R5");
        for (int b = 0; b < 3; b++) cyc(0, 0, 0, 0, v[W-1], 0, "R6");

        // R8: reload same address restarts at bit 0
        cyc(1, 32, 0, 1, v[0], 0, "R8");
        cyc(0, 0, 0, 1, v[1], 0, "R8");

        // R7/R10: scan register 5, hold, change inputs during pause
        v = regv(5, 0);
        cyc(1, 37, 0, 1, v[0], 0, "R2");
        set_regs(1);
        for (int b = 0; b < 3; b++) cyc(0, 0, 1, 1, v[0], 0, "R7");
        for (int b = 1; b < W; b++) cyc(0, 0, 0, 1, v[b], 0, "R10");

        // R9: non-scan address resumes, pin follows field_odd
        cyc(1, 18, 0, 0, 0, 1, "R9");
        cyc(0, 0, 0, 1, 1, 1, "R9");

        // R3: counter 2 at address 53, then reload
        v = cntv(2);
        cyc(1, 53, 0, 1, v[0], 0, "R3");
        for (int b = 1; b < 5; b++) cyc(0, 0, 0, 1, v[b], 0, "R3");
        cyc(1, 53, 0, 1, v[0], 0, "R8");
        cyc(0, 0, 0, 1, v[1], 0, "R8");

        // R3: counter 0 at address 51; switch directly to last register (50)
        v = cntv(0);
        cyc(1, 51, 0, 1, v[0], 0, "R3");
        cyc(0, 0, 0, 1, v[1], 0, "R3");
        v = regv(18, 1);
        cyc(1, 50, 0, 1, v[0], 0, "R2");
        cyc(0, 0, 0, 1, v[1], 0, "R2");

        // R9: address 54 is outside the window
        cyc(1, 54, 0, 0, 0, 1, "R9");
        cyc(1, 31, 0, 1, 1, 1, "R9");
        cyc(0, 0, 0, 1, 1, 1, "R9");

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule